// File: doc/BRIEF.md
# Speculative Store Buffer with Load Forwarding

This block parks the data of stores that have executed but not yet committed, so speculative writes never reach the data cache. Each of its eight (by default) slots holds a word address, a data word and the store's age tag, plus a valid bit and a speculative bit. A store enters as valid and speculative. Its commit clears the speculative bit, and an abort wipes every slot that is still speculative. Committed slots then go to the cache write port one per cycle, oldest first, and each slot is freed when the cache accepts its write.

A load probes the buffer in the same cycle as it reads the cache. It presents its word address, its age tag and the word the cache returned. If a valid slot with the same address holds a store older than the load, the block returns that store's data in place of the cache word. When several slots qualify, the youngest of them wins. Ages are unsigned tags: a smaller value is older. Every access is a whole, word-aligned word.

Top module: `spec_store_buf`

## Requirements
- R1: A store presented on st_valid_i while st_ready_o is high and abort_i is low takes a free slot. From the next cycle that slot is valid and speculative, and it holds the store's address, data and tag.
- R2: cm_valid_i with cm_tag_i equal to the tag of a valid speculative slot clears that slot's speculative bit, and the slot then becomes eligible to drain. A commit tag that matches no such slot has no effect.
- R3: In a cycle with abort_i high, every slot that is still speculative after that cycle's commit becomes invalid, and a store presented in the same cycle is discarded. Committed slots are kept.
- R4: ld_hit_o is high exactly when some valid slot, speculative or committed, has an address equal to ld_addr_i and a tag strictly below ld_tag_i. Slots with an equal or larger tag never forward.
- R5: When several slots qualify, ld_data_o carries the data of the one with the largest tag below ld_tag_i.
- R6: On a hit ld_data_o is the buffer data even if the cache word differs. On a miss ld_data_o equals ld_cache_data_i.
- R7: cwr_valid_o is high whenever a committed slot exists, and cwr_addr_o/cwr_data_o show the committed slot with the smallest tag. A cycle with cwr_ready_i high frees that slot.
- R8: While cwr_ready_i is low and no commit arrives, the presented drain address and data stay unchanged.
- R9: st_ready_o is low when all DEPTH slots are valid, and a store presented then is dropped. A slot freed by a drain becomes usable in the following cycle, not in the cycle of the drain.
- R10: After reset the buffer is empty: st_ready_o is high, cwr_valid_o is low and no load hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Executed store presented |
| st_addr_i | input | AW | Store word address |
| st_data_i | input | DW | Store data word |
| st_tag_i | input | TW | Store age tag |
| st_ready_o | output | 1 | A free slot exists |
| cm_valid_i | input | 1 | Store commit strobe |
| cm_tag_i | input | TW | Tag of the committing store |
| abort_i | input | 1 | Discard all speculative slots |
| ld_addr_i | input | AW | Load probe word address |
| ld_tag_i | input | TW | Load age tag |
| ld_cache_data_i | input | DW | Word read from the cache for this load |
| ld_hit_o | output | 1 | Buffer forwards to this load |
| ld_data_o | output | DW | Load result word |
| cwr_valid_o | output | 1 | Cache write request |
| cwr_addr_o | output | AW | Cache write address |
| cwr_data_o | output | DW | Cache write data |
| cwr_ready_i | input | 1 | Cache accepts the write |

## Verification
Two kinds of events can land in the same cycle and interfere. A commit can arrive with an abort, and a store can be written while a drain frees a slot or while the buffer is full. The bench sets up both cases on purpose. In the directed part, one commit goes out together with an abort and a new store. It also fills the buffer while the cache is stalled, then opens the cache and keeps storing. A pseudo-random phase then mixes stores, commits, aborts and stalls in every combination. A tag-indexed model in the bench predicts the slot contents after each edge. Stalls, drains and forwarding results are judged against that model, and at fixed points a load probe sweeps every address and age.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  typedef enum logic {
    PICK_OLDEST   = 1'b0,
    PICK_YOUNGEST = 1'b1
  } pick_e;
endpackage

// File: rtl/ssb_free_slot.sv
module ssb_free_slot #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  busy_i,
  output logic          full_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy_i[i]) idx_o = IW'(i);
    end
  end

  assign full_o = &busy_i;
endmodule

// File: rtl/ssb_probe_match.sv
module ssb_probe_match #(
  parameter int unsigned N  = 8,
  parameter int unsigned AW = 32,
  parameter int unsigned TW = 6
) (
  input  logic [N-1:0]  valid_i,
  input  logic [AW-1:0] addr_i [N],
  input  logic [TW-1:0] tag_i  [N],
  input  logic [AW-1:0] ld_addr_i,
  input  logic [TW-1:0] ld_tag_i,
  output logic [N-1:0]  match_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (addr_i[g] == ld_addr_i) && (tag_i[g] < ld_tag_i);
  end
endmodule

// File: rtl/ssb_age_pick.sv
module ssb_age_pick
  import ssb_pkg::*;
#(
  parameter int unsigned N    = 8,
  parameter int unsigned TW   = 6,
  parameter pick_e       MODE = PICK_OLDEST,
  parameter int unsigned IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  cand_i,
  input  logic [TW-1:0] tag_i [N],
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  logic [TW-1:0] best_tag;

  always_comb begin
    found_o  = 1'b0;
    idx_o    = '0;
    best_tag = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (!found_o ||
          ((MODE == PICK_YOUNGEST) ? (tag_i[i] > best_tag) : (tag_i[i] < best_tag)))) begin
        found_o  = 1'b1;
        idx_o    = IW'(i);
        best_tag = tag_i[i];
      end
    end
  end
endmodule

// File: rtl/spec_store_buf.sv
module spec_store_buf
  import ssb_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned TW    = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_valid_i,
  input  logic [AW-1:0] st_addr_i,
  input  logic [DW-1:0] st_data_i,
  input  logic [TW-1:0] st_tag_i,
  output logic          st_ready_o,
  input  logic          cm_valid_i,
  input  logic [TW-1:0] cm_tag_i,
  input  logic          abort_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [TW-1:0] ld_tag_i,
  input  logic [DW-1:0] ld_cache_data_i,
  output logic          ld_hit_o,
  output logic [DW-1:0] ld_data_o,
  output logic          cwr_valid_o,
  output logic [AW-1:0] cwr_addr_o,
  output logic [DW-1:0] cwr_data_o,
  input  logic          cwr_ready_i
);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] valid_q, spec_q, valid_d, spec_d;
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [TW-1:0]    tag_q  [DEPTH];

  logic             full;
  logic [IW-1:0]    free_idx;
  logic [DEPTH-1:0] fwd_match;
  logic             fwd_found;
  logic [IW-1:0]    fwd_idx;
  logic [DEPTH-1:0] committed;
  logic             drn_found;
  logic [IW-1:0]    drn_idx;
  logic             wr_en, drain_fire;

  ssb_free_slot #(.N(DEPTH), .IW(IW)) u_free (
    .busy_i (valid_q),
    .full_o (full),
    .idx_o  (free_idx)
  );

  ssb_probe_match #(.N(DEPTH), .AW(AW), .TW(TW)) u_match (
    .valid_i   (valid_q),
    .addr_i    (addr_q),
    .tag_i     (tag_q),
    .ld_addr_i (ld_addr_i),
    .ld_tag_i  (ld_tag_i),
    .match_o   (fwd_match)
  );

  ssb_age_pick #(.N(DEPTH), .TW(TW), .MODE(PICK_YOUNGEST), .IW(IW)) u_fwd_pick (
    .cand_i  (fwd_match),
    .tag_i   (tag_q),
    .found_o (fwd_found),
    .idx_o   (fwd_idx)
  );

  assign committed = valid_q & ~spec_q;

  ssb_age_pick #(.N(DEPTH), .TW(TW), .MODE(PICK_OLDEST), .IW(IW)) u_drn_pick (
    .cand_i  (committed),
    .tag_i   (tag_q),
    .found_o (drn_found),
    .idx_o   (drn_idx)
  );

  assign st_ready_o = !full;
  assign wr_en      = st_valid_i && !full && !abort_i;
  assign drain_fire = drn_found && cwr_ready_i;

  // order: drain release, commit, abort of what is still speculative, allocate
  always_comb begin
    valid_d = valid_q;
    spec_d  = spec_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (drain_fire && drn_idx == IW'(i)) valid_d[i] = 1'b0;
      if (cm_valid_i && valid_q[i] && spec_q[i] && tag_q[i] == cm_tag_i) spec_d[i] = 1'b0;
      if (abort_i && spec_d[i]) begin
        valid_d[i] = 1'b0;
        spec_d[i]  = 1'b0;
      end
      if (wr_en && free_idx == IW'(i)) begin
        valid_d[i] = 1'b1;
        spec_d[i]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      spec_q  <= '0;
    end else begin
      valid_q <= valid_d;
      spec_q  <= spec_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) begin
      addr_q[free_idx] <= st_addr_i;
      data_q[free_idx] <= st_data_i;
      tag_q[free_idx]  <= st_tag_i;
    end
  end

  assign ld_hit_o    = fwd_found;
  assign ld_data_o   = fwd_found ? data_q[fwd_idx] : ld_cache_data_i;
  assign cwr_valid_o = drn_found;
  assign cwr_addr_o  = addr_q[drn_idx];
  assign cwr_data_o  = data_q[drn_idx];

  assert_abort_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> ((valid_q & spec_q) == '0));

  assert_fwd_older_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_hit_o |-> (tag_q[fwd_idx] < ld_tag_i));

  assert_fwd_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_hit_o |-> (valid_q[fwd_idx] && addr_q[fwd_idx] == ld_addr_i));

  assert_drain_committed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cwr_valid_o |-> (valid_q[drn_idx] && !spec_q[drn_idx]));

  assert_drain_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cwr_valid_o && !cwr_ready_i && !cm_valid_i) |=>
      (cwr_valid_o && $stable(cwr_addr_o) && $stable(cwr_data_o)));

  assert_full_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && !st_ready_o) |=> ($countones(valid_q) <= $past($countones(valid_q))));
endmodule

// File: tb/spec_store_buf_test.sv
module spec_store_buf_test;
  localparam int DEPTH = 8;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int TW = 6;
  localparam int NT = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          st_v = 0, cm_v = 0, abort = 0, cwr_rdy = 0;
  logic [AW-1:0] st_a = 0, ld_a = 0;
  logic [DW-1:0] st_d = 0, ld_cd = 0;
  logic [TW-1:0] st_t = 0, cm_t = 0, ld_t = 0;
  logic          st_rdy, ld_hit, cwr_v;
  logic [DW-1:0] ld_d, cwr_d;
  logic [AW-1:0] cwr_a;

  spec_store_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_v), .st_addr_i(st_a), .st_data_i(st_d), .st_tag_i(st_t), .st_ready_o(st_rdy),
    .cm_valid_i(cm_v), .cm_tag_i(cm_t), .abort_i(abort),
    .ld_addr_i(ld_a), .ld_tag_i(ld_t), .ld_cache_data_i(ld_cd),
    .ld_hit_o(ld_hit), .ld_data_o(ld_d),
    .cwr_valid_o(cwr_v), .cwr_addr_o(cwr_a), .cwr_data_o(cwr_d), .cwr_ready_i(cwr_rdy)
  );

  int n_checks = 0;
  int n_errors = 0;

  // bench model, indexed by tag
  bit          m_v [NT];
  bit          m_s [NT];
  logic [AW-1:0] m_a [NT];

  function automatic logic [DW-1:0] dat(int t, logic [AW-1:0] a);
    return {8'hA5, 2'b00, 6'(t), a[15:0]};
  endfunction

  function automatic int m_count();
    int c = 0;
    for (int t = 0; t < NT; t++) if (m_v[t]) c++;
    return c;
  endfunction

  function automatic int m_oldest_committed();
    for (int t = 0; t < NT; t++) if (m_v[t] && !m_s[t]) return t;
    return -1;
  endfunction

  function automatic int m_oldest_spec();
    for (int t = 0; t < NT; t++) if (m_v[t] && m_s[t]) return t;
    return -1;
  endfunction

  function automatic int m_forward(logic [AW-1:0] a, int lt);
    for (int t = lt - 1; t >= 0; t--) if (m_v[t] && m_a[t] == a) return t;
    return -1;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_probe();
    int f;
    f = m_forward(ld_a, int'(ld_t));
    chk(ld_hit == (f >= 0), "R4", "load hit", 32'(ld_hit), 32'(f >= 0));
    if (f >= 0) chk(ld_d == dat(f, m_a[f]), "R5", "forward data", ld_d, dat(f, m_a[f]));
    else        chk(ld_d == ld_cd, "R6", "cache data on miss", ld_d, ld_cd);
  endtask

  task automatic check_outputs();
    int dt;
    chk(st_rdy == (m_count() < DEPTH), "R9", "store ready", 32'(st_rdy), 32'(m_count() < DEPTH));
    dt = m_oldest_committed();
    chk(cwr_v == (dt >= 0), "R7", "drain valid", 32'(cwr_v), 32'(dt >= 0));
    if (dt >= 0) begin
      chk(cwr_a == m_a[dt], "R7", "drain addr", cwr_a, m_a[dt]);
      chk(cwr_d == dat(dt, m_a[dt]), "R7", "drain data", cwr_d, dat(dt, m_a[dt]));
    end
    check_probe();
  endtask

  task automatic model_update();
    int pre, dt;
    pre = m_count();
    dt  = m_oldest_committed();
    if (dt >= 0 && cwr_rdy) m_v[dt] = 0;
    if (cm_v && m_v[cm_t] && m_s[cm_t]) m_s[cm_t] = 0;
    if (abort) for (int t = 0; t < NT; t++) if (m_v[t] && m_s[t]) m_v[t] = 0;
    if (st_v && pre < DEPTH && !abort) begin
      m_v[st_t] = 1; m_s[st_t] = 1; m_a[st_t] = st_a;
    end
  endtask

  task automatic tick();
    #1;
    check_outputs();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    st_v = 0; cm_v = 0; abort = 0;
  endtask

  task automatic store(int t, int a);
    st_v = 1; st_t = TW'(t); st_a = AW'(a); st_d = dat(t, AW'(a));
  endtask

  // state held constant: sweep all probe addresses and ages
  task automatic probe_sweep();
    idle_inputs();
    cwr_rdy = 0;
    for (int a = 0; a < 4; a++) begin
      for (int t = 0; t < NT; t++) begin
        ld_a = AW'(a * 4); ld_t = TW'(t); ld_cd = 32'hC0DE_0000 | 32'(a);
        #1;
        check_probe();
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    int next_tag;
    logic [AW-1:0] held_a;
    for (int t = 0; t < NT; t++) begin m_v[t] = 0; m_s[t] = 0; m_a[t] = '0; end
    repeat (3) @(negedge clk);
    ld_a = 4; ld_t = 63; ld_cd = 32'h1234_5678;
    #1;
    chk(st_rdy == 1'b1, "R10", "ready after reset", 32'(st_rdy), 1);
    chk(cwr_v == 1'b0, "R10", "no drain after reset", 32'(cwr_v), 0);
    chk(ld_hit == 1'b0, "R10", "no hit after reset", 32'(ld_hit), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // fill, cache stalled; tags 9,10 arrive while full
    begin
      int addrs [10] = '{4, 8, 4, 4, 12, 8, 4, 0, 4, 4};
      for (int i = 0; i < 10; i++) begin
        store(i + 1, addrs[i]);
        tick();
      end
    end
    idle_inputs();
    ld_a = 4; ld_t = 63; ld_cd = 32'hFFFF_FFFF;
    #1;
    chk(ld_d == dat(7, 4), "R1", "youngest store visible", ld_d, dat(7, 4));
    chk(st_rdy == 1'b0, "R9", "full stalls", 32'(st_rdy), 0);
    tick();
    probe_sweep();

    // commit 1 and 2; absent tag 50 ignored
    cm_v = 1; cm_t = 1; tick();
    cm_t = 2; tick();
    cm_t = 50; tick();
    cm_v = 0;
    #1;
    chk(cwr_v && cwr_a == 4, "R2", "commit makes oldest drainable", cwr_a, 4);
    chk(st_rdy == 1'b0, "R2", "absent tag commit frees nothing", 32'(st_rdy), 0);
    held_a = cwr_a;
    tick(); tick();
    #1;
    chk(cwr_a == held_a && cwr_d == dat(1, 4), "R8", "drain held under stall", cwr_d, dat(1, 4));

    // drain one slot; same cycle store must be dropped (full before the edge)
    cwr_rdy = 1; store(20, 12); tick();
    cwr_rdy = 0; idle_inputs();
    ld_a = 12; ld_t = 63; #1;
    chk(ld_d == dat(5, 12), "R9", "store in drain cycle dropped", ld_d, dat(5, 12));
    // commit 3 with abort and a new store in one cycle
    store(21, 4); cm_v = 1; cm_t = 3; abort = 1; tick();
    idle_inputs();
    ld_a = 4; ld_t = 63; ld_cd = 0; #1;
    chk(ld_hit && ld_d == dat(3, 4), "R3", "abort keeps committed, drops rest", ld_d, dat(3, 4));
    chk(m_oldest_spec() == -1, "R3", "model has no speculative", 32'(m_oldest_spec()), 32'hFFFF_FFFF);
    tick();
    probe_sweep();

    // drain everything with cache open while refilling
    cwr_rdy = 1;
    store(22, 0); tick();
    store(23, 8); tick();
    idle_inputs(); tick(); tick(); tick();

    // pseudo-random phase
    lfsr = 16'hACE1;
    next_tag = 24;
    for (int c = 0; c < 400; c++) begin
      int os;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      st_v = lfsr[0] && (next_tag < 60);
      st_t = TW'(next_tag); st_a = AW'({lfsr[2:1], 2'b00}); st_d = dat(next_tag, st_a);
      if (st_v) next_tag++;
      os = m_oldest_spec();
      cm_v = lfsr[3] && (os >= 0);
      cm_t = (os >= 0) ? TW'(os) : '0;
      abort = (lfsr[7:4] == 4'hF);
      cwr_rdy = lfsr[8] & lfsr[9];
      ld_a = AW'({lfsr[11:10], 2'b00}); ld_t = TW'(lfsr[15:10]); ld_cd = {16'hBEEF, lfsr};
      tick();
      if (c == 200) begin probe_sweep(); end
    end

    // commit and drain the rest
    idle_inputs();
    cwr_rdy = 1;
    for (int c = 0; c < 30; c++) begin
      int os;
      os = m_oldest_spec();
      cm_v = (os >= 0);
      cm_t = (os >= 0) ? TW'(os) : '0;
      tick();
    end
    idle_inputs();
    tick();
    #1;
    chk(cwr_v == 1'b0 && st_rdy == 1'b1, "R7", "fully drained", 32'(cwr_v), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule